// File: doc/BRIEF.md
# Read Burst Return Scheduler

This block sits in the controller of a double-data-rate memory interface and predicts, slot by slot, when the data of each read will come back. It runs on a clock at twice the memory clock rate, so each tick is one half-cycle slot. This lets it represent a CAS latency of a whole number of cycles and also one with an extra half cycle. For each read it flags a data-valid strobe on the slots where beats will arrive. It also gives the beat number within the burst and the level the data strobe is expected to have on that beat.

The controller strobes a read command, with a flag that says whether the read carries auto precharge. It can also strobe a burst-terminate command. A terminate goes down the same latency pipeline as a read. It cuts the tail of the most recent burst from its own latency point onward. A terminate aimed at an auto-precharge read is rejected and reported. A read that arrives while an earlier burst is still returning takes over from its latency point, so bursts chain without gaps. The capture of the physical data, the DLL and analog skew are handled elsewhere.

Top module: `rd_return_sched`

## Requirements
- R1: A synchronous reset, sampled at a clock edge, clears every pending slot and the burst state. After that edge `beat_valid`, `beat_idx`, `dqs_level` and `bt_illegal` are all 0, and a read strobed just before the reset produces no beats.
- R2: With `cas_half`=0, a read sampled at edge k makes `beat_valid` high for the four slots that follow edges k+4 to k+7, and low otherwise.
- R3: With `cas_half`=1, every beat lands one slot later than with `cas_half`=0. A read sampled at edge k is valid after edges k+5 to k+8. `cas_half` is changed only while no command is in flight.
- R4: `beat_idx` is 0 on the first beat of a burst and rises by one on each following beat, up to 3. When `beat_valid` is low, `beat_idx` is 0.
- R5: `dqs_level` is high on beats with an even index (0 and 2), low on odd beats, and low when no beat is valid.
- R6: A terminate sampled at edge m, when the most recent read had auto precharge disabled, clears every beat scheduled for the slots after edge m+L, where L is the latency in slots. Beats in earlier slots are unchanged.
- R7: A terminate whose most recent read carried auto precharge does not change any beat. `bt_illegal` is high for the single slot after the edge that sampled it.
- R8: A read whose latency point falls while an earlier burst is still returning restarts `beat_idx` at 0 in that slot, drops the rest of the earlier burst, and leaves no gap in `beat_valid`.
- R9: When a read and a terminate are strobed in the same slot, the read is taken and the terminate is dropped. It truncates nothing and does not raise `bt_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Scheduler clock at twice the memory clock; one tick per half-cycle slot |
| rst | input | 1 | Synchronous reset, active high |
| cas_half | input | 1 | 0 selects a whole-cycle latency, 1 adds one half-cycle slot |
| rd_cmd | input | 1 | Read command strobe, one slot wide |
| rd_autopre | input | 1 | Auto precharge flag of the read strobed in the same slot |
| bt_cmd | input | 1 | Burst-terminate command strobe, one slot wide |
| beat_valid | output | 1 | A data beat is expected in this slot |
| beat_idx | output | 2 | Position of the beat within its burst |
| dqs_level | output | 1 | Expected data strobe level for the beat in this slot |
| bt_illegal | output | 1 | Pulse: the terminate just sampled hit an auto-precharge read and was dropped |

## Verification
Two things can meet in one slot. The first is a read and a terminate strobed together, where the read must win and the terminate must vanish without an illegal flag. The second is a new read reaching its latency point while an earlier burst is still returning, which must restart the index at 0 with no idle slot between the bursts. Directed cases place a combined read and terminate both after a plain read and after an auto-precharge read, and place reads two slots apart. Random traffic, under both latencies, strobes reads and terminates independently so that they often coincide. A slot-indexed reference table judges every slot: it applies each accepted command in issue order and clears the tail from each latency point onward.

// File: rtl/ddrrs_pkg.sv
package ddrrs_pkg;

   // One slot of the latency pipeline: an accepted read and/or terminate
   typedef struct packed {
      logic rd;
      logic term;
   } slot_cmd_t;

   // Latency in half-cycle slots for a whole-cycle base plus optional half
   function automatic int unsigned lat_slots(input int unsigned base_cyc,
                                             input bit half);
      return 2 * base_cyc + (half ? 1 : 0);
   endfunction

endpackage

// File: rtl/ddrrs_cmd_intake.sv
module ddrrs_cmd_intake
   import ddrrs_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      rd_cmd,
   input  logic      rd_autopre,
   input  logic      bt_cmd,
   output slot_cmd_t accepted,
   output logic      bt_illegal
);

   logic last_ap_q;
   logic bt_only;

   // a terminate sharing the slot with a read is dropped (read wins)
   assign bt_only       = bt_cmd & ~rd_cmd;
   assign accepted.rd   = rd_cmd;
   assign accepted.term = bt_only & ~last_ap_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         last_ap_q  <= 1'b0;
         bt_illegal <= 1'b0;
      end else begin
         bt_illegal <= bt_only & last_ap_q;
         if (rd_cmd) begin
            last_ap_q <= rd_autopre;
         end
      end
   end

endmodule

// File: rtl/ddrrs_slot_delay.sv
module ddrrs_slot_delay
   import ddrrs_pkg::*;
#(
   parameter int unsigned DEPTH = 5,
   localparam int unsigned TAP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  slot_cmd_t        d,
   input  logic [TAP_W-1:0] tap,
   output slot_cmd_t        q
);

   slot_cmd_t line_q [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) begin
            line_q[i] <= '0;
         end
      end else begin
         line_q[0] <= d;
         for (int i = 1; i < DEPTH; i++) begin
            line_q[i] <= line_q[i-1];
         end
      end
   end

   always_comb begin
      q = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (tap == TAP_W'(i)) begin
            q = line_q[i];
         end
      end
   end

endmodule

// File: rtl/ddrrs_beat_engine.sv
module ddrrs_beat_engine
   import ddrrs_pkg::*;
#(
   parameter int unsigned BURST_LEN = 4,
   localparam int unsigned IDX_W = $clog2(BURST_LEN),
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_LEN - 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  slot_cmd_t        due,
   output logic             beat_valid,
   output logic [IDX_W-1:0] beat_idx,
   output logic             dqs_level
);

   logic             act_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         act_q <= 1'b0;
         idx_q <= '0;
      end else if (due.rd) begin
         act_q <= 1'b1;
         idx_q <= '0;
      end else if (due.term || (act_q && idx_q == LAST_IDX)) begin
         act_q <= 1'b0;
         idx_q <= '0;
      end else if (act_q) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   assign beat_valid = act_q;
   assign beat_idx   = idx_q;
   assign dqs_level  = act_q & ~idx_q[0];

endmodule

// File: rtl/rd_return_sched.sv
module rd_return_sched
   import ddrrs_pkg::*;
#(
   parameter int unsigned BURST_LEN    = 4,
   parameter int unsigned BASE_LAT_CYC = 2,
   parameter bit          HALF_EN      = 1'b1,
   localparam int unsigned IDX_W  = $clog2(BURST_LEN),
   localparam int unsigned MAX_L  = lat_slots(BASE_LAT_CYC, HALF_EN),
   localparam int unsigned TAP_W  = (MAX_L > 1) ? $clog2(MAX_L) : 1
) (
   input  logic             clk2x,
   input  logic             rst,
   input  logic             cas_half,
   input  logic             rd_cmd,
   input  logic             rd_autopre,
   input  logic             bt_cmd,
   output logic             beat_valid,
   output logic [IDX_W-1:0] beat_idx,
   output logic             dqs_level,
   output logic             bt_illegal
);

   if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_bl
      $error("BURST_LEN must be a power of two of at least 2");
   end
   if (BASE_LAT_CYC < 1) begin : g_bad_lat
      $error("BASE_LAT_CYC must be at least 1");
   end

   slot_cmd_t        acc;
   slot_cmd_t        due;
   logic [TAP_W-1:0] tap;

   ddrrs_cmd_intake u_intake (
      .clk        (clk2x),
      .rst        (rst),
      .rd_cmd     (rd_cmd),
      .rd_autopre (rd_autopre),
      .bt_cmd     (bt_cmd),
      .accepted   (acc),
      .bt_illegal (bt_illegal)
   );

   // tap L-1 of the line feeds the engine, which registers once more
   if (HALF_EN) begin : g_half
      assign tap = TAP_W'(2 * BASE_LAT_CYC - 1) + TAP_W'(cas_half);
   end else begin : g_whole
      logic unused_cas;
      assign unused_cas = cas_half;
      assign tap        = TAP_W'(2 * BASE_LAT_CYC - 1);
   end

   ddrrs_slot_delay #(.DEPTH(MAX_L)) u_line (
      .clk (clk2x),
      .rst (rst),
      .d   (acc),
      .tap (tap),
      .q   (due)
   );

   ddrrs_beat_engine #(.BURST_LEN(BURST_LEN)) u_engine (
      .clk        (clk2x),
      .rst        (rst),
      .due        (due),
      .beat_valid (beat_valid),
      .beat_idx   (beat_idx),
      .dqs_level  (dqs_level)
   );

endmodule

// File: rtl/rd_return_sched_chk.sv
module rd_return_sched_chk #(
   parameter int unsigned BURST_LEN = 4,
   localparam int unsigned IDX_W = $clog2(BURST_LEN),
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_LEN - 1)
) (
   input logic             clk2x,
   input logic             rst,
   input logic             rd_cmd,
   input logic             bt_cmd,
   input logic             beat_valid,
   input logic [IDX_W-1:0] beat_idx,
   input logic             dqs_level,
   input logic             bt_illegal
);

   a_r1_reset_quiet: assert property (@(posedge clk2x)
      rst |=> (!beat_valid && !bt_illegal && !dqs_level && beat_idx == '0));

   a_r4_idx_idle_zero: assert property (@(posedge clk2x) disable iff (rst)
      !beat_valid |-> beat_idx == '0);

   a_r4_idx_steps: assert property (@(posedge clk2x) disable iff (rst)
      (beat_valid && $past(beat_valid) && beat_idx != '0)
         |-> beat_idx == $past(beat_idx) + 1'b1);

   a_r5_dqs_even_only: assert property (@(posedge clk2x) disable iff (rst)
      dqs_level |-> (beat_valid && !beat_idx[0]));

   a_r8_burst_bound: assert property (@(posedge clk2x) disable iff (rst)
      (beat_valid && beat_idx == LAST_IDX) |=> (!beat_valid || beat_idx == '0));

   a_r7_illegal_needs_term: assert property (@(posedge clk2x) disable iff (rst)
      bt_illegal |-> $past(bt_cmd));

   a_r9_read_wins: assert property (@(posedge clk2x) disable iff (rst)
      $past(rd_cmd && bt_cmd) |-> !bt_illegal);

endmodule

bind rd_return_sched rd_return_sched_chk #(.BURST_LEN(BURST_LEN)) u_chk (
   .clk2x      (clk2x),
   .rst        (rst),
   .rd_cmd     (rd_cmd),
   .bt_cmd     (bt_cmd),
   .beat_valid (beat_valid),
   .beat_idx   (beat_idx),
   .dqs_level  (dqs_level),
   .bt_illegal (bt_illegal)
);

// File: tb/tb_rd_return_sched.sv
module tb_rd_return_sched;

   localparam int BL   = 4;
   localparam int BASE = 2;
   localparam int NT   = 8192;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cas_half = 1'b0;
   logic       rd_cmd = 1'b0;
   logic       rd_autopre = 1'b0;
   logic       bt_cmd = 1'b0;
   logic       beat_valid;
   logic [1:0] beat_idx;
   logic       dqs_level;
   logic       bt_illegal;

   rd_return_sched dut (
      .clk2x      (clk),
      .rst        (rst),
      .cas_half   (cas_half),
      .rd_cmd     (rd_cmd),
      .rd_autopre (rd_autopre),
      .bt_cmd     (bt_cmd),
      .beat_valid (beat_valid),
      .beat_idx   (beat_idx),
      .dqs_level  (dqs_level),
      .bt_illegal (bt_illegal)
   );

   always #4 clk = ~clk;

   int edge_n = 0;
   always @(posedge clk) edge_n <= edge_n + 1;

   logic [2:0] exp_vi  [NT];
   logic       exp_ill [NT];
   bit         last_ap = 1'b0;
   int         n_chk = 0;
   int         n_err = 0;
   string      tag = "R1";
   bit         done = 1'b0;

   function automatic int lat();
      return 2 * BASE + (cas_half ? 1 : 0);
   endfunction

   task automatic check(input string t, input int act, input int exp_v);
      n_chk++;
      if (act != exp_v) begin
         n_err++;
         $display("FAIL %s edge %0d: actual %0d expected %0d", t, edge_n, act, exp_v);
      end
   endtask

   task automatic clear_from(input int s);
      for (int i = s; i < s + BL + 8 && i < NT; i++) exp_vi[i] = 3'b000;
   endtask

   // drive one slot, update the reference, wait, compare
   task automatic tick(input bit r, input bit ap, input bit b, input bit rs);
      int e;
      e = edge_n + 1;
      rst = rs; rd_cmd = r; rd_autopre = ap; bt_cmd = b;
      if (rs) begin
         for (int i = e; i < NT; i++) begin
            exp_vi[i] = 3'b000; exp_ill[i] = 1'b0;
         end
         last_ap = 1'b0;
      end else if (r) begin
         clear_from(e + lat());
         for (int j = 0; j < BL; j++) exp_vi[e + lat() + j] = {1'b1, 2'(j)};
         last_ap = ap;
      end else if (b) begin
         if (last_ap) exp_ill[e] = 1'b1;
         else clear_from(e + lat());
      end
      @(negedge clk);
      check(tag, int'(beat_valid), int'(exp_vi[edge_n][2]));
      check("R4", int'(beat_idx), int'(exp_vi[edge_n][1:0]));
      check("R5", int'(dqs_level), int'(exp_vi[edge_n][2] & ~exp_vi[edge_n][0]));
      check("R7", int'(bt_illegal), int'(exp_ill[edge_n]));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick(0, 0, 0, 0);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      for (int i = 0; i < NT; i++) begin
         exp_vi[i] = 3'b000; exp_ill[i] = 1'b0;
      end
      void'($urandom(32'd2718));
      @(negedge clk);
      // R1: reset state
      tag = "R1";
      for (int i = 0; i < 3; i++) tick(0, 0, 0, 1);
      idle(4);
      // R2: whole-cycle latency
      tag = "R2"; tick(1, 0, 0, 0); idle(12);
      // R3: half-cycle extra
      cas_half = 1'b1;
      tag = "R3"; tick(1, 0, 0, 0); idle(12);
      cas_half = 1'b0;
      // R6: terminate two slots after the read
      tag = "R6"; tick(1, 0, 0, 0); idle(1); tick(0, 0, 1, 0); idle(12);
      cas_half = 1'b1;
      tick(1, 0, 0, 0); idle(2); tick(0, 0, 1, 0); idle(12);
      cas_half = 1'b0;
      // R7: terminate at auto-precharge read
      tag = "R7"; tick(1, 1, 0, 0); tick(0, 0, 1, 0); idle(12);
      // R8: back-to-back reads
      tag = "R8"; tick(1, 0, 0, 0); idle(1); tick(1, 0, 0, 0); idle(2); tick(1, 0, 0, 0); idle(12);
      // R9: read and terminate together
      tag = "R9"; tick(1, 0, 0, 0); idle(1); tick(1, 0, 1, 0); idle(12);
      tick(1, 1, 0, 0); tick(1, 0, 1, 0); idle(12);
      // R1: pending read flushed by reset
      tag = "R1"; tick(1, 0, 0, 0); tick(0, 0, 0, 1); tick(0, 0, 0, 1); idle(12);
      // random traffic, both latencies
      tag = "R8";
      for (int ph = 0; ph < 6; ph++) begin
         cas_half = ph[0];
         for (int i = 0; i < 800; i++) begin
            tick(($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 6) == 0, 0);
         end
         idle(12);
      end
      summary();
   end

endmodule